// File: doc/BRIEF.md
# Signed Double-Width by Single-Width Divider

This block divides a signed dividend of twice the word width by a signed single-width divisor and returns a quotient, a remainder and four condition flags (negative, zero, overflow, carry), following the rules of a classic 16-bit minicomputer divide instruction. The dividend arrives as a high word and a low word and is read as a two's-complement number formed by the high word shifted up one word plus the low word. The divisor is read as a two's-complement word. Quotients truncate toward zero. A nonzero remainder carries the sign of the dividend.

A one-cycle `start` pulse presents the operands. Operands that cannot produce a valid result are sorted out at once: a zero divisor, an out-of-range dividend, or a dividend so large relative to the divisor that the quotient cannot fit the iteration. In those cases the result is ready one cycle later. All other operands go through a magnitude loop that produces one quotient bit per clock, followed by a sign-correction cycle. That cycle also catches a quotient that exceeds the signed word range. `done` pulses for one cycle, and the outputs hold until the next result.

Top module: `sdiv_long`

## Requirements
- R1: For a successful divide, `quo` equals the dividend divided by the divisor truncated toward zero, and `rem` equals dividend minus quotient times divisor, so a nonzero remainder has the dividend's sign (34 / -5 gives -6 rem 4; -34 / 5 gives -6 rem -4).
- R2: On success, the flags are V=0 and C=0, N=1 exactly when the quotient is negative, and Z=1 exactly when the quotient is zero.
- R3: A zero divisor gives N=0, Z=1, V=1, C=1 for every dividend. This check takes precedence over every other check.
- R4: With a nonzero divisor, a dividend above +1073774591 or below -1073741823 (for W=16) gives V=1, C=0, Z=0, and N equal to the XOR of the dividend and divisor sign bits.
- R5: A true quotient outside -32768..+32767 gives V=1, C=0, Z=0, and N equal to the XOR of the operand signs. For example, -32768 / -1 overflows, while -32767 / -1 gives 32767.
- R6: A quotient of exactly -32768 is a legal result when the remainder magnitude is below the divisor magnitude (divisor -21846, remainder 21845). With a larger remainder magnitude, the same case is an overflow.
- R7: Whenever V=1, `quo` carries the dividend high word and `rem` carries the dividend low word unchanged.
- R8: `done` rises one cycle after an accepted start when the divisor is zero, the dividend is out of range, or |dividend| >= |divisor| * 2^(W+1). In every other case it rises W+2 cycles after the accepted start.
- R9: `busy` is high from the cycle after an accepted iterating start until `done` rises. A start while `busy` is high is ignored and leaves the pending result unchanged.
- R10: `done` is high for exactly one cycle. `quo`, `rem` and the flags change only in the cycle where `done` rises and hold their values otherwise.
- R11: During reset, `busy`, `done`, `quo`, `rem` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled with the operands |
| dd_hi | input | W | Dividend high word |
| dd_lo | input | W | Dividend low word |
| dvs | input | W | Divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle result strobe |
| quo | output | W | Quotient |
| rem | output | W | Remainder |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Divide-by-zero flag |

## Verification
The bench builds the block with the default W=16. This makes the exact range limits, the -32768 quotient boundary, and the divisor extremes -32768 and +32767 reachable with literal operand values. Directed vectors surround each of these edges with remainders just inside and just outside the legal range. Random operand sets built from divisor, quotient and remainder mix successful divides with late overflows. Starts issued mid-loop exercise the ignore rule.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOOP = 2'd1,
        PH_FIX  = 2'd2
    } phase_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/sdiv_classify.sv
// Operand magnitudes and the checks that end a divide before the loop.
module sdiv_classify #(
    parameter int W = 16
) (
    input  logic [W-1:0]   dd_hi,
    input  logic [W-1:0]   dd_lo,
    input  logic [W-1:0]   dvs,
    output logic [2*W-1:0] dd_mag,
    output logic [W:0]     dv_mag,
    output logic           q_neg,
    output logic           dv_zero,
    output logic           range_bad,
    output logic           q_wide
);
    localparam int DDW = 2 * W;
    localparam int QMW = W + 1;
    localparam logic signed [DDW:0] ONE    = 1;
    localparam logic signed [DDW:0] HI_LIM = (ONE <<< (DDW - 2)) + (ONE <<< (W - 1)) - ONE;
    localparam logic signed [DDW:0] LO_LIM = ONE - (ONE <<< (DDW - 2));

    logic [DDW-1:0]       dd_raw;
    logic signed [DDW:0]  dd_ext;
    logic [W:0]           dv_ext;
    logic                 dd_neg;
    logic                 dv_neg;

    always_comb begin
        dd_raw    = {dd_hi, dd_lo};
        dd_neg    = dd_raw[DDW-1];
        dv_neg    = dvs[W-1];
        dd_ext    = $signed({dd_neg, dd_raw});
        dv_ext    = {dv_neg, dvs};
        dd_mag    = dd_neg ? (~dd_raw + 1'b1) : dd_raw;
        dv_mag    = dv_neg ? (~dv_ext + 1'b1) : dv_ext;
        q_neg     = dd_neg ^ dv_neg;
        dv_zero   = (dvs == '0);
        range_bad = (dd_ext > HI_LIM) || (dd_ext < LO_LIM);
        q_wide    = ({2'b00, dd_mag[DDW-1:QMW]} >= dv_mag);
    end
endmodule

// File: rtl/sdiv_step.sv
// One restoring division step: shift in a dividend bit, try the subtract.
module sdiv_step #(
    parameter int W = 16
) (
    input  logic [W:0] p_in,
    input  logic       bit_in,
    input  logic [W:0] b,
    output logic [W:0] p_out,
    output logic       q_bit
);
    logic [W+1:0] p_sh;
    logic [W+1:0] diff;

    always_comb begin
        p_sh  = {p_in, bit_in};
        diff  = p_sh - {1'b0, b};
        q_bit = ~diff[W+1];
        p_out = q_bit ? diff[W:0] : p_sh[W:0];
    end
endmodule

// File: rtl/sdiv_finish.sv
// Applies result signs and detects a quotient beyond the signed word range.
module sdiv_finish #(
    parameter int W = 16
) (
    input  logic [W:0]   qmag,
    input  logic [W-1:0] rmag,
    input  logic         q_neg,
    input  logic         dd_neg,
    output logic [W-1:0] q,
    output logic [W-1:0] r,
    output logic         ovf,
    output logic         n,
    output logic         z
);
    localparam logic [W:0] NEG_LIM = (W + 1)'(1) << (W - 1);
    localparam logic [W:0] POS_LIM = NEG_LIM - 1'b1;

    always_comb begin
        ovf = q_neg ? (qmag > NEG_LIM) : (qmag > POS_LIM);
        q   = q_neg ? (~qmag[W-1:0] + 1'b1) : qmag[W-1:0];
        r   = dd_neg ? (~rmag + 1'b1) : rmag;
        n   = q[W-1];
        z   = (q == '0);
    end
endmodule

// File: rtl/sdiv_long.sv
module sdiv_long
    import sdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dd_hi,
    input  logic [W-1:0] dd_lo,
    input  logic [W-1:0] dvs,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c
);
    localparam int DDW = 2 * W;
    localparam int QMW = W + 1;
    localparam int CW  = $clog2(QMW + 1);

    typedef struct packed {
        phase_e         phase;
        logic [CW-1:0]  cnt;
        logic [W:0]     part;
        logic [QMW-1:0] qsh;
        logic [W:0]     bmag;
        logic [DDW-1:0] dd;
        logic           q_neg;
        logic           done;
        logic [W-1:0]   quo;
        logic [W-1:0]   rem;
        nzvc_t          flg;
    } regs_t;

    regs_t r_q, r_d;

    logic [DDW-1:0] c_dd_mag;
    logic [W:0]     c_dv_mag;
    logic           c_q_neg, c_dv_zero, c_range_bad, c_q_wide;
    logic [W:0]     s_part;
    logic           s_bit;
    logic [W-1:0]   f_q, f_r;
    logic           f_ovf, f_n, f_z;

    sdiv_classify #(.W(W)) u_classify (
        .dd_hi    (dd_hi),
        .dd_lo    (dd_lo),
        .dvs      (dvs),
        .dd_mag   (c_dd_mag),
        .dv_mag   (c_dv_mag),
        .q_neg    (c_q_neg),
        .dv_zero  (c_dv_zero),
        .range_bad(c_range_bad),
        .q_wide   (c_q_wide)
    );

    sdiv_step #(.W(W)) u_step (
        .p_in  (r_q.part),
        .bit_in(r_q.qsh[QMW-1]),
        .b     (r_q.bmag),
        .p_out (s_part),
        .q_bit (s_bit)
    );

    sdiv_finish #(.W(W)) u_finish (
        .qmag  (r_q.qsh),
        .rmag  (r_q.part[W-1:0]),
        .q_neg (r_q.q_neg),
        .dd_neg(r_q.dd[DDW-1]),
        .q     (f_q),
        .r     (f_r),
        .ovf   (f_ovf),
        .n     (f_n),
        .z     (f_z)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.dd    = {dd_hi, dd_lo};
                    r_d.q_neg = c_q_neg;
                    r_d.bmag  = c_dv_mag;
                    r_d.part  = {2'b00, c_dd_mag[DDW-1:QMW]};
                    r_d.qsh   = c_dd_mag[QMW-1:0];
                    r_d.cnt   = '0;
                    if (c_dv_zero) begin
                        r_d.done  = 1'b1;
                        r_d.quo   = dd_hi;
                        r_d.rem   = dd_lo;
                        r_d.flg.n = 1'b0;
                        r_d.flg.z = 1'b1;
                        r_d.flg.v = 1'b1;
                        r_d.flg.c = 1'b1;
                    end else if (c_range_bad || c_q_wide) begin
                        r_d.done  = 1'b1;
                        r_d.quo   = dd_hi;
                        r_d.rem   = dd_lo;
                        r_d.flg.n = c_q_neg;
                        r_d.flg.z = 1'b0;
                        r_d.flg.v = 1'b1;
                        r_d.flg.c = 1'b0;
                    end else begin
                        r_d.phase = PH_LOOP;
                    end
                end
            end
            PH_LOOP: begin
                r_d.part = s_part;
                r_d.qsh  = {r_q.qsh[QMW-2:0], s_bit};
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(QMW - 1)) begin
                    r_d.phase = PH_FIX;
                end
            end
            PH_FIX: begin
                r_d.phase = PH_IDLE;
                r_d.done  = 1'b1;
                r_d.flg.c = 1'b0;
                if (f_ovf) begin
                    r_d.quo   = r_q.dd[DDW-1:W];
                    r_d.rem   = r_q.dd[W-1:0];
                    r_d.flg.n = r_q.q_neg;
                    r_d.flg.z = 1'b0;
                    r_d.flg.v = 1'b1;
                end else begin
                    r_d.quo   = f_q;
                    r_d.rem   = f_r;
                    r_d.flg.n = f_n;
                    r_d.flg.z = f_z;
                    r_d.flg.v = 1'b0;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.phase != PH_IDLE);
    assign done   = r_q.done;
    assign quo    = r_q.quo;
    assign rem    = r_q.rem;
    assign flag_n = r_q.flg.n;
    assign flag_z = r_q.flg.z;
    assign flag_v = r_q.flg.v;
    assign flag_c = r_q.flg.c;

    // R1
    part_lt_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_LOOP) |-> (r_q.part < r_q.bmag));

    // R2
    good_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flag_v) |-> (!flag_c && (flag_n == quo[W-1]) && (flag_z == (quo == '0))));

    // R3
    zero_div_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_c) |-> (flag_v && flag_z && !flag_n));

    // R5
    fail_not_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v && !flag_c) |-> !flag_z);

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> ((quo == r_q.dd[DDW-1:W]) && (rem == r_q.dd[W-1:0])));

    // R9
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo) && $stable(rem) && $stable(flag_n) && $stable(flag_z)
                   && $stable(flag_v) && $stable(flag_c)));
endmodule

// File: tb/sdiv_long_bench.sv
`timescale 1ns/1ps
module sdiv_long_bench;
    localparam int W   = 16;
    localparam int LAT = W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] dd_hi = '0, dd_lo = '0, dvs = '0;
    logic busy, done, flag_n, flag_z, flag_v, flag_c;
    logic [W-1:0] quo, rem;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 0;

    sdiv_long #(.W(W)) u_sdiv_long (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dd_hi(dd_hi), .dd_lo(dd_lo), .dvs(dvs),
        .busy(busy), .done(done), .quo(quo), .rem(rem),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    always #10 clk = ~clk;

    // reference model state
    bit m_busy, m_done, m_was_busy;
    int m_pend;
    logic [15:0] m_quo, m_rem, p_quo, p_rem;
    bit [3:0] m_flg, p_flg;
    string m_rtag, m_ftag, p_rtag, p_ftag;

    // results of one model computation
    logic [15:0] c_quo, c_rem;
    bit [3:0] c_flg;
    bit c_fast;
    string c_rtag, c_ftag;

    function automatic void compute(input logic [15:0] h, input logic [15:0] l,
                                    input logic [15:0] dv);
        longint dd, d, ad, adv, q, r;
        bit sx;
        dd = longint'($signed({h, l}));
        d  = longint'($signed(dv));
        ad  = (dd < 0) ? -dd : dd;
        adv = (d < 0) ? -d : d;
        sx = (dd < 0) ^ (d < 0);
        c_quo = h; c_rem = l;
        if (d == 0) begin
            c_flg = 4'b0111; c_fast = 1; c_rtag = "R7"; c_ftag = "R3";
        end else if (dd > 64'sd1073774591 || dd < -64'sd1073741823) begin
            c_flg = {sx, 3'b010}; c_fast = 1; c_rtag = "R7"; c_ftag = "R4";
        end else begin
            c_fast = (ad >= adv * 131072);
            q = dd / d;
            r = dd - q * d;
            if (q > 32767 || q < -32768) begin
                c_flg = {sx, 3'b010}; c_rtag = "R7"; c_ftag = "R5";
            end else begin
                c_quo = q[15:0]; c_rem = r[15:0];
                c_flg = {q < 0, q == 0, 2'b00};
                c_rtag = (q == -32768) ? "R6" : "R1";
                c_ftag = "R2";
            end
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_pend = 0;
            m_quo = '0; m_rem = '0; m_flg = '0;
            m_rtag = "R11"; m_ftag = "R11";
        end else begin
            m_was_busy = m_busy;
            m_done = 0;
            if (m_pend > 0) begin
                m_pend = m_pend - 1;
                if (m_pend == 0) begin
                    m_done = 1; m_busy = 0;
                    m_quo = p_quo; m_rem = p_rem; m_flg = p_flg;
                    m_rtag = p_rtag; m_ftag = p_ftag;
                end
            end
            if (start && !m_was_busy) begin
                compute(dd_hi, dd_lo, dvs);
                if (c_fast) begin
                    m_done = 1;
                    m_quo = c_quo; m_rem = c_rem; m_flg = c_flg;
                    m_rtag = c_rtag; m_ftag = c_ftag;
                end else begin
                    m_busy = 1; m_pend = LAT;
                    p_quo = c_quo; p_rem = c_rem; p_flg = c_flg;
                    p_rtag = c_rtag; p_ftag = c_ftag;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R8", "done", done, m_done);
            chk("R9", "busy", busy, m_busy);
            if (m_done) begin
                chk(m_rtag, "quo", quo, m_quo);
                chk(m_rtag, "rem", rem, m_rem);
                chk(m_ftag, "nzvc", {flag_n, flag_z, flag_v, flag_c}, m_flg);
            end else begin
                chk("R10", "quo hold", quo, m_quo);
                chk("R10", "rem hold", rem, m_rem);
                chk("R10", "nzvc hold", {flag_n, flag_z, flag_v, flag_c}, m_flg);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL R8 watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic go(input longint dd, input longint dv);
        logic [31:0] w;
        logic [15:0] d;
        w = dd[31:0];
        d = dv[15:0];
        @(negedge clk);
        dd_hi = w[31:16]; dd_lo = w[15:0]; dvs = d; start = 1;
        @(negedge clk);
        start = 0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic go_dqr(input longint dv, input longint q, input longint r);
        go(dv * q + r, dv);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R11 reset state
        chk("R11", "busy", busy, 0);
        chk("R11", "done", done, 0);
        chk("R11", "quo", quo, 0);
        chk("R11", "rem", rem, 0);
        chk("R11", "nzvc", {flag_n, flag_z, flag_v, flag_c}, 0);
        rst_n = 1;

        // R1 R2 small signs
        for (int a = -4; a <= 4; a++) begin
            go(a, 3);
            go(a, -3);
        end
        // R3 zero divisor, including an out-of-range dividend
        go(0, 0); go(1, 0); go(-1, 0); go(64'sh7fffffff, 0);
        // R1 quadrants
        go(34, 5); go(34, -5); go(-34, 5); go(-34, -5);
        // R6 quotient -32768 boundary
        for (int r = 21843; r <= 21848; r++) begin
            go_dqr(-21846, -32768, r);
            go_dqr(21846, -32768, -r);
            go_dqr(-21847, -32768, r);
            go_dqr(21847, -32768, -r);
            go_dqr(21846, 32767, r);
            go_dqr(-21846, 32767, -r);
        end
        // divisor extremes
        for (int q = 1; q <= 4; q++) begin
            go_dqr(-32768, q, 0); go_dqr(-32768, q, -1); go_dqr(-32768, q, -32767);
            go_dqr(32767, q, 0); go_dqr(32767, -q, -32766); go_dqr(32767, q, 32766);
        end
        go_dqr(-32768, -32768, 0); go_dqr(-32768, -32768, 1);
        go_dqr(-32768, 32767, -32767); go_dqr(32767, -32768, -1);
        // R4 dividend range edges
        go_dqr(-32768, -32768, 32767); go_dqr(-32768, -32768, 32768);
        go_dqr(32767, 32767, 32766); go_dqr(32767, 32767, 32767);
        go_dqr(-32768, 32767, -32767); go_dqr(-32768, 32767, -32768);
        go(64'sh7fffffff, 1); go(64'sh7fffffff, -2);
        go(-64'sh80000000, 1); go(-64'sh80000000, -1);
        // R5 late quit
        go(-32767, -1); go(-32768, -1); go(-32769, -1);
        go(-65534, -2); go(-65535, -2); go(-65536, -2); go(-65537, -2);

        // R9 start while busy is ignored
        @(negedge clk);
        dd_hi = 16'h0000; dd_lo = 16'd1000; dvs = 16'd7; start = 1;
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        dd_hi = 16'h0000; dd_lo = 16'd5; dvs = 16'd0; start = 1;
        @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        dd_lo = 16'd99; dvs = 16'd4; start = 1;
        @(negedge clk); start = 0;
        repeat (LAT + 2) @(negedge clk);

        // random operands from divisor, quotient, remainder
        for (int i = 0; i < 300; i++) begin
            longint dv, q, r, adv;
            dv = longint'($signed(16'($urandom)));
            if (dv == 0) dv = 1;
            adv = (dv < 0) ? -dv : dv;
            q = longint'($signed(16'($urandom)));
            r = longint'($urandom % 32'(adv));
            if ($urandom % 2 == 1) r = -r;
            go_dqr(dv, q, r);
        end
        // random raw dividends
        for (int i = 0; i < 100; i++) begin
            go(longint'($signed(32'($urandom))) >>> ($urandom % 24),
               longint'($signed(16'($urandom))));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule